// File: doc/BRIEF.md
# Reserved-Quarter Slot Allocator

This block keeps the ownership state of a fixed pool of message buffer slots. Outgoing (transmit) traffic and incoming (receive) traffic share the pool. Each slot has one busy flag. A client raises an allocation request and marks it as transmit or receive. In the same cycle the block answers with the index of a free slot, or with a failure flag when it finds no eligible free slot. At the next clock edge the granted slot becomes busy. A separate release port clears the busy flag of any slot.

The lowest quarter of the pool is kept for receive buffers only. Transmit requests start their search at index POOL_SIZE/4. A backlog of outgoing messages can therefore never use up the buffers needed to accept the responses that would drain it. The block holds no message data and no queue links. It also applies no retry policy. It only decides which slot goes to which requester. POOL_SIZE must be a multiple of 4 (default 64). A free-count output reports how many slots are idle.

Top module: `msgslot_alloc`

## Requirements
- R1: After reset every slot is idle: `free_count` equals POOL_SIZE, and a receive request returns slot 0.
- R2: A receive request (`alloc_tx`=0) is granted the lowest-numbered eligible free slot, searching from index 0 upward.
- R3: A transmit request (`alloc_tx`=1) is granted the lowest-numbered eligible free slot at or above index POOL_SIZE/4. A transmit grant never names an index below POOL_SIZE/4.
- R4: A granted slot is busy from the following clock edge. It is not granted again until it has been released.
- R5: When no eligible slot is free, a request gives `alloc_fail`=1, `alloc_gnt`=0 and `alloc_idx`=0, and no busy flag changes. With no request, both `alloc_gnt` and `alloc_fail` are 0.
- R6: A transmit request fails once slots POOL_SIZE/4 through POOL_SIZE-1 are all busy, even if slots in the reserved lower quarter are still free. A receive request still succeeds in that state.
- R7: A release (`rel_valid`=1) clears the flag of slot `rel_idx` at the next edge, whatever its state. Releasing an idle slot leaves it idle and does not change `free_count`.
- R8: A release and a request in the same cycle are resolved release-first. The slot being released is eligible for that same cycle's grant, and it stays busy if it is re-granted.
- R9: `free_count` equals the number of slots whose busy flag is clear. It reflects every grant and release from the edge at which that grant or release takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Allocation request, one per cycle |
| alloc_tx | input | 1 | 1 = transmit request, 0 = receive request |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_fail | output | 1 | Request refused, no eligible free slot |
| alloc_idx | output | $clog2(POOL_SIZE) | Granted slot index (0 when not granted) |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | $clog2(POOL_SIZE) | Slot to release |
| free_count | output | $clog2(POOL_SIZE+1) | Number of idle slots |

## Verification
The bench targets the reserved-quarter boundary. It fills the upper part of the pool with transmit grants and checks that transmit then fails while receive still lands in the lower quarter. A design with the wrong start index would give away a reserved slot or skip a legal one. It also targets the same-cycle release-and-grant case. A design that resolves it grant-first would skip the released slot, or would free a slot it had just handed out. Long pseudo-random mixes of requests and releases, including releases of idle slots, cover the priority order. In those mixes, an off-by-one free count or a double grant shows up as soon as it happens.

// File: rtl/msgslot_pkg.sv
package msgslot_pkg;

    // Traffic class of an allocation request
    typedef enum logic {
        KIND_RX = 1'b0,
        KIND_TX = 1'b1
    } slot_kind_e;

    // First slot a transmit request may take
    function automatic int tx_floor(input int pool);
        return pool / 4;
    endfunction

endpackage

// File: rtl/msgslot_elig.sv
module msgslot_elig #(
    parameter int POOL_SIZE = 64,
    parameter int TX_BASE   = 16
) (
    input  logic [POOL_SIZE-1:0] free_vec,
    input  logic                 is_tx,
    output logic [POOL_SIZE-1:0] elig_vec
);
    genvar g;
    generate
        for (g = 0; g < POOL_SIZE; g++) begin : g_slot
            if (g < TX_BASE) begin : g_reserved
                // reserved quarter: receive traffic only
                assign elig_vec[g] = free_vec[g] & ~is_tx;
            end else begin : g_shared
                assign elig_vec[g] = free_vec[g];
            end
        end
    endgenerate
endmodule

// File: rtl/msgslot_prio_enc.sv
module msgslot_prio_enc #(
    parameter int N = 64,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msgslot_popcount.sv
module msgslot_popcount #(
    parameter int N = 64,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/msgslot_alloc.sv
module msgslot_alloc
    import msgslot_pkg::*;
#(
    parameter int POOL_SIZE = 64,
    localparam int IDX_W   = $clog2(POOL_SIZE),
    localparam int CNT_W   = $clog2(POOL_SIZE + 1),
    localparam int TX_BASE = tx_floor(POOL_SIZE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             alloc_tx,
    output logic             alloc_gnt,
    output logic             alloc_fail,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    output logic [CNT_W-1:0] free_count
);
    slot_kind_e             req_kind;
    logic [POOL_SIZE-1:0]   busy_q;
    logic [POOL_SIZE-1:0]   busy_d;
    logic [POOL_SIZE-1:0]   rel_mask;
    logic [POOL_SIZE-1:0]   gnt_mask;
    logic [POOL_SIZE-1:0]   free_now;
    logic [POOL_SIZE-1:0]   free_state;
    logic [POOL_SIZE-1:0]   elig;
    logic                   hit;
    logic [IDX_W-1:0]       hit_idx;

    assign req_kind = slot_kind_e'(alloc_tx);

    // Release decode: release-first, so a slot freed this cycle is grantable
    genvar g;
    generate
        for (g = 0; g < POOL_SIZE; g++) begin : g_rel
            assign rel_mask[g] = rel_valid && (rel_idx == IDX_W'(g));
            assign gnt_mask[g] = alloc_gnt && (alloc_idx == IDX_W'(g));
        end
    endgenerate

    assign free_now   = ~busy_q | rel_mask;
    assign free_state = ~busy_q;

    msgslot_elig #(
        .POOL_SIZE (POOL_SIZE),
        .TX_BASE   (TX_BASE)
    ) u_elig (
        .free_vec (free_now),
        .is_tx    (req_kind == KIND_TX),
        .elig_vec (elig)
    );

    msgslot_prio_enc #(
        .N (POOL_SIZE)
    ) u_enc (
        .vec   (elig),
        .found (hit),
        .idx   (hit_idx)
    );

    msgslot_popcount #(
        .N (POOL_SIZE)
    ) u_cnt (
        .vec (free_state),
        .cnt (free_count)
    );

    // Handshake outputs
    always_comb begin
        alloc_gnt  = alloc_req && hit;
        alloc_fail = alloc_req && !hit;
        alloc_idx  = alloc_gnt ? hit_idx : '0;
    end

    // Busy flag update: clear released slot, then set granted slot
    assign busy_d = (busy_q & ~rel_mask) | gnt_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= busy_d;
        end
    end

    // Assertions
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |-> (!alloc_gnt && !alloc_fail)); // R5
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (alloc_gnt != alloc_fail)); // R5
    AST_TX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && alloc_tx) |-> ({1'b0, alloc_idx} >= (IDX_W+1)'(TX_BASE))); // R3
    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> (!busy_q[alloc_idx] || (rel_valid && rel_idx == alloc_idx))); // R8
    AST_GRANT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> busy_q[$past(alloc_idx)]); // R4
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !(alloc_gnt && alloc_idx == rel_idx)) |=> !busy_q[$past(rel_idx)]); // R7
    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fail && !rel_valid) |=> $stable(busy_q)); // R5
endmodule

// File: tb/msgslot_alloc_bench.sv
module msgslot_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int POOL  = 8;
    localparam int IDX_W = $clog2(POOL);
    localparam int CNT_W = $clog2(POOL + 1);
    localparam int BASE  = POOL / 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_req = 1'b0;
    logic             alloc_tx = 1'b0;
    logic             alloc_gnt;
    logic             alloc_fail;
    logic [IDX_W-1:0] alloc_idx;
    logic             rel_valid = 1'b0;
    logic [IDX_W-1:0] rel_idx = '0;
    logic [CNT_W-1:0] free_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit m_busy [POOL];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgslot_alloc #(.POOL_SIZE(POOL)) u_msgslot_alloc (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_tx(alloc_tx),
        .alloc_gnt(alloc_gnt), .alloc_fail(alloc_fail), .alloc_idx(alloc_idx),
        .rel_valid(rel_valid), .rel_idx(rel_idx),
        .free_count(free_count)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_free();
        int n = 0;
        for (int i = 0; i < POOL; i++) if (!m_busy[i]) n++;
        return n;
    endfunction

    // One cycle: drive, check combinational answer, advance model at the edge
    task automatic step(input bit req, input bit tx, input bit rv, input int ri, input string tag);
        int exp_idx;
        bit exp_g;
        @(negedge clk);
        alloc_req = req; alloc_tx = tx; rel_valid = rv; rel_idx = IDX_W'(ri);
        #1;
        exp_g = 0; exp_idx = 0;
        if (req) begin
            for (int i = (tx ? BASE : 0); i < POOL; i++) begin
                if (!exp_g && (!m_busy[i] || (rv && ri == i))) begin
                    exp_g = 1; exp_idx = i;
                end
            end
        end
        check(tag, int'(alloc_gnt), int'(exp_g), "grant");
        check(tag, int'(alloc_fail), int'(req && !exp_g), "fail");
        check(tag, int'(alloc_idx), exp_idx, "index");
        check("R9", int'(free_count), model_free(), "free_count");
        if (rv) m_busy[ri] = 0;
        if (exp_g) m_busy[exp_idx] = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < POOL; i++) m_busy[i] = 0;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", int'(free_count), POOL, "free_count after reset");
        check("R1", int'(alloc_gnt), 0, "no grant without request");
        step(1, 0, 0, 0, "R1");
        // R2 fill from the bottom with receive requests, then fail (R5)
        for (int k = 1; k < POOL; k++) step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R5");
        step(1, 1, 0, 0, "R5");
        step(0, 0, 0, 0, "R5");
        // R7 release everything
        for (int k = 0; k < POOL; k++) step(0, 0, 1, k, "R7");
        // R7 release of an idle slot
        step(0, 0, 1, 3, "R7");
        check("R7", int'(free_count), POOL, "idle release leaves count");
        // R3 transmit fills upper part only
        for (int k = BASE; k < POOL; k++) step(1, 1, 0, 0, "R3");
        // R6 transmit refused while reserved quarter free, receive still served
        step(1, 1, 0, 0, "R6");
        check("R6", int'(free_count), BASE, "reserved slots untouched");
        step(1, 0, 0, 0, "R6");
        // R8 release and grant same slot in one cycle
        step(1, 1, 1, 5, "R8");
        step(1, 1, 0, 0, "R4");
        // R4 granted slot not handed out again
        step(1, 0, 1, 0, "R8");
        // drain
        for (int k = 0; k < POOL; k++) step(0, 0, 1, k, "R7");
        // pseudo-random mix
        for (int n = 0; n < 3000; n++) begin
            bit rq, tx, rv;
            int ri;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rq = lfsr[0] | lfsr[5];
            tx = lfsr[1];
            rv = lfsr[2] & lfsr[7];
            ri = int'(lfsr[10:8]);
            step(rq, tx, rv, ri, tx ? "R3" : "R2");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule